// File: doc/BRIEF.md
# Hierarchical Page-Table Walker

This block maps a 64-bit virtual address from the upper half of the address space to a physical address. It reads hierarchical translation tables from memory, one 8-byte little-endian descriptor per level. A single-cycle `start` pulse latches four inputs: the virtual address, a control word (region size, granule, output-range code, extended-descriptor flag), a root word holding the first table's address, and a capability word that limits the output range. The walk depth is decided at run time. It depends on the virtual-address width and on the granule. The output address can reach 52 bits, and two descriptor layouts are supported for the bits above 47.

The walker has one descriptor read outstanding at most. It drives a valid/ready request with a byte address and waits for a response carrying 64 data bits. When the walk ends it pulses `done` with `pa_out` valid, or it pulses `fault` when the output-range code is unsupported. There is no result cache, no permission check and no second stage.

Control flow is a state machine with six states:
- **IDLE**: waits for `start`.
- **CHECK**: decodes the latched configuration. It goes to DONE on a pass-through, to FAULT on a bad range code, and otherwise to ISSUE.
- **ISSUE**: presents the descriptor read and moves to WAIT on the handshake.
- **WAIT**: waits for the response. It goes back to ISSUE to descend a level, or to DONE at a leaf.
- **DONE** and **FAULT**: one-cycle result states that return to IDLE.

Top module: `ptw_top`

## Requirements
- R1: When virtual-address bit 55 is 0, the walker issues no memory request and pulses `done` with `pa_out` equal to the input address.
- R2: When the 6-bit region-size field (control bits 21:16) is 0, the walker also passes the address through unchanged with no request. This check only applies when bit 55 is 1.
- R3: The output-range code is the smaller of control bits 34:32 and capability bits 3:0. Codes 0..6 select 32, 36, 40, 42, 44, 48 and 52 bits. A code above 6 pulses `fault` with no memory request; a pass-through (R1/R2) takes priority over this fault.
- R4: Granule code 3 (control bits 31:30) gives a stride of 13 bits, code 1 gives 11 bits, and any other code gives 9 bits. With vsz = 64 − size field, the first level is 4 − (vsz − 4)/stride, using integer division. Level L uses shift = stride·(4 − L).
- R5: Each read address is the table address ORed with (VA >> shift), masked to vsz − shift bits at the first level and to stride+3 bits at later levels. The low 3 bits of the result are cleared. The first table address is root bits 47:0; when the range code is 6, root bits 5:2 also supply address bits 51:48.
- R6: When descriptor bit 1 is 1 and the level is below 3, the walker descends one level. Otherwise the walk stops after that read.
- R7: The next table address is the descriptor ANDed with a mask. The mask keeps 50 low bits when control bit 59 is 1 and 48 low bits otherwise, and always clears the low stride+3 bits.
- R8: With range code 6 and control bit 59 = 0, descriptor bits 15:12 become address bits 51:48.
- R9: With range code 6 and control bit 59 = 1, descriptor bits 9:8 become address bits 51:50.
- R10: The final region is 2^(shift+3) bytes. `pa_out` takes the descriptor-derived address above that size and the VA bits below it.
- R11: A request is held stable until it is accepted. Only one read is outstanding at a time, and `start` is ignored while `busy` is 1.
- R12: `done` and `fault` are single-cycle pulses and are never high together. After reset, `busy`, `done`, `fault` and `req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only in IDLE) |
| va_in | input | 64 | Virtual address to translate |
| ctl_word | input | 64 | Translation-control word |
| root_word | input | 64 | First-table address word |
| cap_word | input | 64 | Output-range capability word |
| req_valid | output | 1 | Descriptor read request |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Byte address of the descriptor |
| rsp_valid | input | 1 | Descriptor data returned |
| rsp_data | input | 64 | Descriptor, little-endian 64-bit |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Unsupported-range pulse |
| pa_out | output | 64 | Translated address |

## Verification
The assertions check every cycle that:
- a pending request holds its address until accepted;
- the latched address cannot change during a walk;
- the result pulses are single-cycle and exclusive;
- a pass-through or range fault follows CHECK in the next cycle without touching memory;
- a leaf response never leads to another request.

Only the bench's scenarios show the rest. These are the depth chosen per granule and width, the index and mask arithmetic, the scattered high address bits in both 52-bit layouts, and the final merge of page and VA bits. The bench checks them against tables it builds and against a behavioural walk, under varying ready stalls and response latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        PTW_IDLE,
        PTW_CHECK,
        PTW_ISSUE,
        PTW_WAIT,
        PTW_DONE,
        PTW_FAULT
    } ptw_state_e;

    // Latched slices of the control word
    typedef struct packed {
        logic       xdesc;   // extended descriptor layout flag
        logic [2:0] ips;     // requested output range code
        logic [1:0] gran;    // granule code
        logic [5:0] shrink;  // region size field
    } ptw_ctl_t;

    // Decoded walk configuration
    typedef struct packed {
        logic        pass;      // return address unchanged
        logic        bad_range; // range code above 6
        logic        wide;      // 52-bit output
        logic        xdesc;
        logic [3:0]  stride;
        logic [2:0]  steps0;    // 4 - first level
        logic [6:0]  width0;    // first-level index width
        logic [63:0] next_mask;
        logic [63:0] root;
    } ptw_cfg_t;

    function automatic logic [63:0] low_ones(input logic [6:0] w);
        if (w >= 7'd64) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

endpackage

// File: rtl/ptw_cfg_decode.sv
module ptw_cfg_decode
    import ptw_pkg::*;
#(
    parameter int RANGE_BIT = 55,
    parameter int ROOT_W    = 48,
    parameter int WIDE_CODE = 6
) (
    input  logic [63:0]   va,
    input  ptw_ctl_t      ctl,
    input  logic [47:0]   root_lo,
    input  logic [3:0]    cap,
    output ptw_cfg_t      cfg
);
    localparam int VA_TOTAL = 64;
    localparam logic [6:0] NARROW_MASK_W = 7'd48;
    localparam logic [6:0] EXT_MASK_W    = 7'd50;

    logic [6:0] vsz;
    logic [6:0] num;
    logic [3:0] code;
    logic [3:0] stride;
    logic [2:0] steps;

    always_comb begin
        vsz = 7'(VA_TOTAL) - {1'b0, ctl.shrink};
        num = (vsz >= 7'd4) ? (vsz - 7'd4) : 7'd0;
        unique case (ctl.gran)
            2'd3:    begin stride = 4'd13; steps = 3'(num / 7'd13); end
            2'd1:    begin stride = 4'd11; steps = 3'(num / 7'd11); end
            default: begin stride = 4'd9;  steps = 3'(num / 7'd9);  end
        endcase
        code = ({1'b0, ctl.ips} < cap) ? {1'b0, ctl.ips} : cap;

        cfg.pass      = !va[RANGE_BIT] || (ctl.shrink == 6'd0);
        cfg.bad_range = code > 4'(WIDE_CODE);
        cfg.wide      = code == 4'(WIDE_CODE);
        cfg.xdesc     = ctl.xdesc;
        cfg.stride    = stride;
        cfg.steps0    = steps;
        cfg.width0    = vsz - 7'(stride) * 7'(steps);
        cfg.next_mask = low_ones(ctl.xdesc ? EXT_MASK_W : NARROW_MASK_W)
                      & ~low_ones(7'(stride) + 7'd3);
        cfg.root      = {{(64-ROOT_W){1'b0}}, root_lo};
        if (cfg.wide)
            cfg.root[51:48] = root_lo[5:2];
    end
endmodule

// File: rtl/ptw_desc_next.sv
module ptw_desc_next
    import ptw_pkg::*;
(
    input  logic [63:0] desc,
    input  ptw_cfg_t    cfg,
    output logic [63:0] next_addr
);
    always_comb begin
        next_addr = desc & cfg.next_mask;
        if (cfg.wide) begin
            if (cfg.xdesc)
                next_addr[51:50] = desc[9:8];
            else
                next_addr[51:48] = desc[15:12];
        end
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int RANGE_BIT = 55,
    parameter int ROOT_W    = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] va_in,
    input  logic [63:0] ctl_word,
    input  logic [63:0] root_word,
    input  logic [63:0] cap_word,
    output logic        req_valid,
    input  logic        req_ready,
    output logic [63:0] req_addr,
    input  logic        rsp_valid,
    input  logic [63:0] rsp_data,
    output logic        busy,
    output logic        done,
    output logic        fault,
    output logic [63:0] pa_out
);
    localparam logic [2:0] LAST_STEP = 3'd1;

    ptw_state_e  state_q, state_d;
    logic [63:0] va_q;
    ptw_ctl_t    ctl_q;
    logic [47:0] root_q;
    logic [3:0]  cap_q;
    logic [63:0] tbl_q;
    logic [2:0]  steps_q;
    logic [6:0]  width_q;
    logic [63:0] pa_q;

    ptw_cfg_t    cfg;
    logic [63:0] next_addr;
    logic [6:0]  shamt;
    logic [6:0]  region;
    logic        descend;

    logic unused_bits;
    assign unused_bits = ^{ctl_word[63:60], ctl_word[58:35], ctl_word[29:22],
                           ctl_word[15:0], root_word[63:ROOT_W], cap_word[63:4]};

    ptw_cfg_decode #(.RANGE_BIT(RANGE_BIT), .ROOT_W(ROOT_W)) u_dec (
        .va      (va_q),
        .ctl     (ctl_q),
        .root_lo (root_q),
        .cap     (cap_q),
        .cfg     (cfg)
    );

    ptw_desc_next u_next (
        .desc      (rsp_data),
        .cfg       (cfg),
        .next_addr (next_addr)
    );

    assign shamt   = 7'(cfg.stride) * 7'(steps_q);
    assign region  = shamt + 7'd3;
    assign descend = rsp_data[1] && (steps_q > LAST_STEP);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTW_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTW_IDLE:  if (start) state_d = PTW_CHECK;
            PTW_CHECK: begin
                if (cfg.pass)           state_d = PTW_DONE;
                else if (cfg.bad_range) state_d = PTW_FAULT;
                else                    state_d = PTW_ISSUE;
            end
            PTW_ISSUE: if (req_ready) state_d = PTW_WAIT;
            PTW_WAIT:  if (rsp_valid) state_d = descend ? PTW_ISSUE : PTW_DONE;
            PTW_DONE:  state_d = PTW_IDLE;
            PTW_FAULT: state_d = PTW_IDLE;
            default:   state_d = PTW_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = state_q != PTW_IDLE;
        req_valid = state_q == PTW_ISSUE;
        done      = state_q == PTW_DONE;
        fault     = state_q == PTW_FAULT;
        req_addr  = (tbl_q | ((va_q >> shamt) & low_ones(width_q))) & ~64'd7;
        pa_out    = pa_q;
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            ctl_q   <= '0;
            root_q  <= '0;
            cap_q   <= '0;
            tbl_q   <= '0;
            steps_q <= '0;
            width_q <= '0;
            pa_q    <= '0;
        end else begin
            unique case (state_q)
                PTW_IDLE: if (start) begin
                    va_q   <= va_in;
                    ctl_q  <= '{xdesc: ctl_word[59], ips: ctl_word[34:32],
                               gran: ctl_word[31:30], shrink: ctl_word[21:16]};
                    root_q <= root_word[ROOT_W-1:0];
                    cap_q  <= cap_word[3:0];
                end
                PTW_CHECK: begin
                    if (cfg.pass) begin
                        pa_q <= va_q;
                    end else if (!cfg.bad_range) begin
                        tbl_q   <= cfg.root;
                        steps_q <= cfg.steps0;
                        width_q <= cfg.width0;
                    end
                end
                PTW_WAIT: if (rsp_valid) begin
                    if (descend) begin
                        tbl_q   <= next_addr;
                        steps_q <= steps_q - 3'd1;
                        width_q <= 7'(cfg.stride) + 7'd3;
                    end else begin
                        pa_q <= (next_addr & ~low_ones(region)) | (va_q & low_ones(region));
                    end
                end
                default: ;
            endcase
        end
    end

    // R11: a stalled request keeps its address
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    // R11: start during a walk does not disturb the latched address
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && !fault |=> $stable(va_q));

    // R12: result pulses last one cycle and never coincide
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R1 / R2: pass-through completes at once with the input address
    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PTW_CHECK) && cfg.pass |=> done && (pa_out == $past(va_q)));

    // R3: bad range faults without a memory request
    p_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PTW_CHECK) && !cfg.pass && cfg.bad_range |=> fault && !req_valid);

    // R6: a response at the last level ends the walk
    p_leaf_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PTW_WAIT) && rsp_valid && (steps_q <= LAST_STEP) |=> done && !req_valid);

endmodule

// File: tb/ptw_top_test.sv
module ptw_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] va_in = '0, ctl_word = '0, root_word = '0, cap_word = '0;
    logic        req_valid, req_ready = 1'b0;
    logic [63:0] req_addr;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_data = '0;
    logic        busy, done, fault;
    logic [63:0] pa_out;

    int checks = 0;
    int failures = 0;

    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_q [$];
    int          reads = 0;
    int          lat = 0;
    int          stall_mod = 3;
    logic [63:0] alloc = 64'h0000_0000_4000_0000;

    always #2 clk = ~clk;

    ptw_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .va_in(va_in),
        .ctl_word(ctl_word), .root_word(root_word), .cap_word(cap_word),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
        .done(done), .fault(fault), .pa_out(pa_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] lm(input int w);
        if (w >= 64) return '1;
        if (w <= 0) return '0;
        return (64'd1 << w) - 64'd1;
    endfunction

    function automatic logic [63:0] mk_ctl(input int shrink, input int gran, input int ips, input bit xd);
        return (64'(shrink) << 16) | (64'(gran) << 30) | (64'(ips) << 32) | (64'(xd) << 59);
    endfunction

    // Memory responder and per-cycle comparison of the request stream
    initial begin
        bit          pend = 0;
        int          cd = 0;
        int          tick = 0;
        logic [63:0] paddr = '0;
        forever begin
            @(negedge clk);
            chk(!(done && fault), "R12 done/fault overlap", {62'b0, done, fault}, 64'd0);
            rsp_valid = 1'b0;
            if (pend) begin
                if (cd == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = mem.exists(paddr) ? mem[paddr] : 64'd0;
                    pend = 0;
                end else cd--;
            end
            req_ready = 1'b0;
            if (req_valid && !pend && !rsp_valid) begin
                tick++;
                if ((tick % stall_mod) != 1) begin
                    req_ready = 1'b1;
                    reads++;
                    if (exp_q.size() == 0)
                        chk(0, "R5 unexpected request", req_addr, 64'd0);
                    else begin
                        logic [63:0] e;
                        e = exp_q.pop_front();
                        chk(req_addr == e, "R5 read address", req_addr, e);
                    end
                    pend = 1; cd = lat; paddr = req_addr;
                end
            end
        end
    end

    // Builds tables along the path and predicts the reads and the result
    task automatic run_case(input string tag, input logic [63:0] va, input logic [63:0] ctl,
                            input logic [63:0] root, input logic [63:0] cap, input int leaf,
                            input logic [63:0] target, input bit poke);
        int kind, shrink, vsz, stride, lvl, w, code, sz, nreads;
        bit xd, wide;
        logic [63:0] tbl, a, nxt, d, exp_pa;
        exp_q.delete();
        reads = 0; nreads = 0; exp_pa = '0;
        shrink = int'(ctl[21:16]);
        xd = ctl[59];
        code = (int'(ctl[34:32]) < int'(cap[3:0])) ? int'(ctl[34:32]) : int'(cap[3:0]);
        if (!va[55] || shrink == 0) begin kind = 1; exp_pa = va; end
        else if (code > 6) kind = 2;
        else begin
            kind = 0;
            wide = (code == 6);
            vsz = 64 - shrink;
            stride = (ctl[31:30] == 2'd3) ? 13 : (ctl[31:30] == 2'd1) ? 11 : 9;
            lvl = 4 - (vsz - 4) / stride;
            w = vsz - stride * (4 - lvl);
            tbl = root & lm(48);
            if (wide) tbl |= ((root >> 2) & 64'hF) << 48;
            forever begin
                a = (tbl | ((va >> (stride * (4 - lvl))) & lm(w))) & ~64'd7;
                exp_q.push_back(a);
                nreads++;
                if (lvl < leaf) begin
                    nxt = alloc; alloc += 64'h1_0000;
                    d = nxt & lm(xd ? 50 : 48) & ~lm(stride + 3);
                    if (wide) d |= xd ? (((nxt >> 50) & 64'h3) << 8) : (((nxt >> 48) & 64'hF) << 12);
                    mem[a] = d | 64'd3;
                    tbl = nxt; w = stride + 3; lvl++;
                end else begin
                    sz = stride * (4 - lvl) + 3;
                    d = target & lm(xd ? 50 : 48) & ~lm(sz);
                    if (wide) d |= xd ? (((target >> 50) & 64'h3) << 8) : (((target >> 48) & 64'hF) << 12);
                    mem[a] = d | 64'd1 | ((lvl == 3) ? 64'd2 : 64'd0);
                    exp_pa = (target & ~lm(sz)) | (va & lm(sz));
                    break;
                end
            end
        end

        @(negedge clk);
        start = 1'b1; va_in = va; ctl_word = ctl; root_word = root; cap_word = cap;
        @(negedge clk);
        start = 1'b0; va_in = ~va;
        for (int i = 0; i < 3000; i++) begin
            if (done || fault) break;
            if (poke && i == 4) begin start = 1'b1; va_in = va ^ 64'h0000_00F0_0000_0000; end
            if (poke && i == 5) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        if (kind == 2) begin
            chk(fault && !done, {tag, " R3 fault"}, {63'b0, fault}, 64'd1);
        end else begin
            chk(done && !fault, {tag, " R12 done"}, {63'b0, done}, 64'd1);
            chk(pa_out == exp_pa, {tag, " R10 pa_out"}, pa_out, exp_pa);
        end
        chk(reads == nreads, {tag, " R6 read count"}, 64'(reads), 64'(nreads));
        @(negedge clk);
        chk(!done && !fault && !busy, {tag, " R12 single pulse"}, {61'b0, done, fault, busy}, 64'd0);
        if (poke) begin
            repeat (10) @(negedge clk);
            chk(!busy && !done && reads == nreads, {tag, " R11 start ignored while busy"},
                64'(reads), 64'(nreads));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !req_valid, "R12 reset state",
            {60'b0, busy, done, fault, req_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: low-range address passes through
        run_case("R1", 64'h0000_1234_5678_9ABC, mk_ctl(16, 0, 5, 0), 64'h4000_0000, 64'd5, 3, 0, 0);
        // R2: zero size field passes through
        run_case("R2", 64'hFFFF_8000_0000_1000, mk_ctl(0, 0, 5, 0), 64'h4000_0000, 64'd5, 3, 0, 0);
        // R3: range code 7 faults
        run_case("R3", 64'hFFFF_8000_0000_1000, mk_ctl(16, 0, 7, 0), 64'h4000_0000, 64'd15, 3, 0, 0);

        // R4 R5 R6: 4KB, 48-bit VA, four levels to a page
        lat = 0; stall_mod = 3;
        run_case("R4 4KB page", 64'hFFFF_8012_3456_7ABC, mk_ctl(16, 0, 5, 0), 64'h0000_0000_3000_0000,
                 64'd5, 3, 64'h0000_00AB_CDEF_0000, 0);
        // R6: block entry at level 2
        lat = 2;
        run_case("R6 4KB block", 64'hFFFF_8765_4321_0FED, mk_ctl(16, 0, 5, 0), 64'h0000_0000_3001_0000,
                 64'd5, 2, 64'h0000_0001_4020_0000, 0);
        // R4 R3: 16KB, 47-bit VA, range min(4,6)=44 bits
        lat = 1; stall_mod = 2;
        run_case("R4 16KB", 64'hFFFF_C0DE_F00D_1357, mk_ctl(17, 1, 4, 0), 64'h0000_0000_3002_0000,
                 64'd6, 3, 64'h0000_0003_2100_4000, 0);
        // R4 R3: 64KB, 42-bit VA, range min(7,2)=40 bits
        lat = 3; stall_mod = 4;
        run_case("R4 64KB", 64'hFFFF_FF12_3456_789A, mk_ctl(22, 3, 7, 0), 64'h0000_0000_3003_0000,
                 64'd2, 3, 64'h0000_0000_05A7_0000, 0);
        // R7: extended mask without wide output, block at level 1
        lat = 0; stall_mod = 3;
        run_case("R7 ext mask", 64'hFFFF_9ABC_DEF0_1234, mk_ctl(16, 0, 5, 1), 64'h0000_0000_3004_0000,
                 64'd5, 1, 64'h0000_0040_0000_0000, 0);

        // R8: 52-bit, 64KB granule, high bits in descriptor 15:12
        alloc = 64'h000A_0000_0100_0000;
        run_case("R8 wide 64KB", 64'hFFF5_6789_ABCD_1234, mk_ctl(12, 3, 6, 0),
                 64'h0000_0000_0200_0000 | (64'h9 << 2), 64'd6, 3, 64'h000C_1234_5678_0000, 0);
        // R9: 52-bit, 4KB granule, level -1 start, high bits in descriptor 9:8
        alloc = 64'h000D_0000_0100_0000;
        lat = 1;
        run_case("R9 wide 4KB", 64'hFFFA_BCDE_F012_3456, mk_ctl(12, 0, 6, 1),
                 64'h0000_0000_0300_0000 | (64'hB << 2), 64'd7, 3, 64'h000E_0001_2345_6000, 0);

        // R11: start pulsed mid-walk is ignored
        alloc = 64'h0000_0000_5000_0000;
        lat = 2;
        run_case("R11 busy", 64'hFFFF_8111_2222_3333, mk_ctl(16, 0, 5, 0), 64'h0000_0000_3005_0000,
                 64'd5, 3, 64'h0000_0012_3456_7000, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule